// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash and decides whether a program or erase operation that has already been launched has finished, and whether it worked. After a start pulse it reads the device status word over a request/response read port. It compares bit 6 between two consecutive reads. If bit 6 has stopped changing, the operation is complete. If bit 6 is still changing and neither error flag (bit 3 or bit 5) is up, it starts a fresh pair of reads. If a flag is up, it takes one more pair of reads before it gives a verdict. The extra pair is needed because the toggling can stop in the same cycle that the flag rises.

A two-bit mode input chooses how the device is left afterwards. With mode `00`, a successful operation leaves the device alone, and only a failure is followed by a single write of the exit command. With any other mode value, the exit command is written after every verdict. The exit address and data are parameters. A poll limit parameter ends a loop that never settles and reports it as a failure. The verdict is given by a one-cycle `done` pulse. `pass` and `fail` are held steady from that pulse until the next start.

Top module: `tgl_poll_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `done`, `pass`, `fail`, `rd_req_valid` and `wr_valid` are 0.
- R2: After a start, status reads go out one at a time. `rd_req_valid` stays high until `rd_req_ready` is seen. The next request is issued only after the `rd_rsp_valid` of the previous one.
- R3: If bit 6 is equal in the two reads of a pair, the verdict is pass, whatever bits 3 and 5 hold.
- R4: If bit 6 differs and bits 3 and 5 of the second read are both 0, the engine issues a new pair of reads.
- R5: If bit 6 differs and bit 3 or bit 5 of the second read is 1, two more reads follow. If bit 6 is equal across those two reads, the verdict is pass.
- R6: If bit 6 still differs across the recheck pair, the verdict is fail.
- R7: When `MAX_POLLS` consecutive pairs toggle with both flags clear, the verdict is fail and no further read is issued.
- R8: With mode `00`, a pass issues no write and a fail issues exactly one write.
- R9: With any nonzero mode, exactly one write is issued after either verdict. The mode is sampled at start.
- R10: The write presents `EXIT_ADDR` and `EXIT_DATA` and is held until `wr_ready`. `done` rises one cycle after the write is accepted. When no write is due, `done` rises one cycle after the final response.
- R11: `done` is high for exactly one cycle, and exactly one of `pass` and `fail` is high with it. Both stay unchanged until the next accepted start.
- R12: A `start` that arrives while a poll is in progress, and a mode change made at that time, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| cfg_exit_mode | input | 2 | 00: exit write on failure only; other values: exit write always |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Operation completed successfully |
| fail | output | 1 | Operation failed or timed out |
| rd_req_valid | output | 1 | Status read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_rsp_valid | input | 1 | Status word returned |
| rd_rsp_data | input | DW | Status word |
| wr_valid | output | 1 | Exit command write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Exit command address |
| wr_data | output | DW | Exit command data |

## Verification
A read request appears one cycle after start or after a response. The verdict is fixed at the edge that takes the last response. From there, either `wr_valid` or `done` appears one cycle later, and `done` follows an accepted write by one cycle. The bench's reference model replays each scripted status sequence to predict the verdict, the number of reads and whether a write is due. On every clock it records the cycle of each response and write handshake, and it checks `done` against the single cycle in which it is due. Random-free stall patterns on both ready inputs and on response latency move those handshake cycles, so the due cycle is always derived from observed events and never from fixed offsets.

// File: rtl/tgl_poll_pkg.sv
// Shared definitions for the toggle-bit completion poller.
// Assumes the status word carries the toggle bit and both error flags
// at the fixed positions below.
package tgl_poll_pkg;

    localparam int TGL_BIT = 6;   // bit that flips on each read while busy
    localparam int ERR_LO  = 3;   // first error/timeout flag
    localparam int ERR_HI  = 5;   // second error/timeout flag

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_EXIT,
        ST_DONE
    } tp_state_e;

endpackage

// File: rtl/tgl_pair_cmp.sv
// Remembers the toggle bit of the first read of a pair and compares the
// second read against it. Also decodes the error flags of the live word.
// Assumes load_first is pulsed on the first response of every pair.
module tgl_pair_cmp
    import tgl_poll_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_first,
    input  logic [DW-1:0] rsp_data,
    output logic          toggled,
    output logic          err_seen
);

    logic ref_bit;
    logic unused_bits;

    // Capture the toggle bit of the first read of each pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_bit <= 1'b0;
        end else if (load_first) begin
            ref_bit <= rsp_data[TGL_BIT];
        end
    end

    // Compare and flag decode on the current response word.
    always_comb begin
        toggled  = ref_bit ^ rsp_data[TGL_BIT];
        err_seen = rsp_data[ERR_LO] | rsp_data[ERR_HI];
    end

    assign unused_bits = ^rsp_data;

endmodule

// File: rtl/tgl_poll_ctr.sv
// Counts unsettled polling pairs and flags the last allowed one.
// Assumes inc is never raised while at_limit is high (the caller fails out).
module tgl_poll_ctr #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

    logic [CW-1:0] cnt;

    // Pair counter, cleared at each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign at_limit = (cnt == CW'(MAX_POLLS - 1));

    // R7: the count never passes the last allowed pair.
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_POLLS - 1));

endmodule

// File: rtl/tgl_poll_engine.sv
// Toggle-bit completion poller. It issues paired status reads, decides pass
// or fail from the toggle bit and the error flags (with a recheck pair once
// a flag is seen), and optionally writes an exit command before strobing done.
// Assumes one outstanding read at a time and a responder that eventually answers.
module tgl_poll_engine
    import tgl_poll_pkg::*;
#(
    parameter int             DW        = 16,
    parameter int             AW        = 20,
    parameter int             MAX_POLLS = 1024,
    parameter logic [AW-1:0]  EXIT_ADDR = '0,
    parameter logic [DW-1:0]  EXIT_DATA = DW'('h00F0)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_exit_mode,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          rd_req_valid,
    input  logic          rd_req_ready,
    input  logic          rd_rsp_valid,
    input  logic [DW-1:0] rd_rsp_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    tp_state_e state;
    logic      second_rd;     // waiting for the second read of a pair
    logic      recheck;       // current pair is the post-flag recheck
    logic      mode_always;   // exit command after every verdict
    logic      pass_q;
    logic      fail_q;

    logic      toggled;
    logic      err_seen;
    logic      at_limit;
    logic      rsp_take;
    logic      pair_end;
    logic      ctr_clr;
    logic      ctr_inc;

    assign rsp_take = (state == ST_WAIT) && rd_rsp_valid;
    assign pair_end = rsp_take && second_rd;
    assign ctr_clr  = (state == ST_IDLE) && start;
    assign ctr_inc  = pair_end && toggled && !recheck && !err_seen && !at_limit;

    tgl_pair_cmp #(.DW(DW)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_first (rsp_take && !second_rd),
        .rsp_data   (rd_rsp_data),
        .toggled    (toggled),
        .err_seen   (err_seen)
    );

    tgl_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctr_clr),
        .inc      (ctr_inc),
        .at_limit (at_limit)
    );

    // Sequencer: read pairs, decide, optional exit write, done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            second_rd   <= 1'b0;
            recheck     <= 1'b0;
            mode_always <= 1'b0;
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_always <= (cfg_exit_mode != 2'b00);
                        second_rd   <= 1'b0;
                        recheck     <= 1'b0;
                        pass_q      <= 1'b0;
                        fail_q      <= 1'b0;
                        state       <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (rd_req_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rd_rsp_valid) begin
                        if (!second_rd) begin
                            second_rd <= 1'b1;
                            state     <= ST_REQ;
                        end else begin
                            second_rd <= 1'b0;
                            if (!toggled) begin
                                pass_q <= 1'b1;
                                state  <= mode_always ? ST_EXIT : ST_DONE;
                            end else if (recheck || at_limit && !err_seen) begin
                                fail_q <= 1'b1;
                                state  <= ST_EXIT;
                            end else if (err_seen) begin
                                recheck <= 1'b1;
                                state   <= ST_REQ;
                            end else begin
                                state <= ST_REQ;
                            end
                        end
                    end
                end
                ST_EXIT: begin
                    if (wr_ready) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the sequencer state.
    always_comb begin
        rd_req_valid = (state == ST_REQ);
        wr_valid     = (state == ST_EXIT);
        wr_addr      = EXIT_ADDR;
        wr_data      = EXIT_DATA;
        done         = (state == ST_DONE);
        pass         = pass_q;
        fail         = fail_q;
    end

    // R2: a pending read request is not withdrawn.
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid);

    // R2: an accepted request is not followed at once by another.
    p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && rd_req_ready |=> !rd_req_valid);

    // R8, R9: exit write only after a failure or in the always-exit mode.
    p_exit_when_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (fail || mode_always));

    // R10: a pending exit write is held with stable address.
    p_exit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));

    // R11: done is a single-cycle strobe.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: exactly one verdict flag accompanies done.
    p_verdict_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones({pass, fail}) == 1);

    // R11: the verdict is held while idle without a start.
    p_verdict_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && !start |=> $stable(pass) && $stable(fail));

endmodule

// File: tb/tgl_poll_engine_tb.sv
`timescale 1ns/1ps
module tgl_poll_engine_tb;

    localparam int            DW   = 16;
    localparam int            AW   = 8;
    localparam int            MAXP = 5;
    localparam logic [AW-1:0] EA   = 8'h55;
    localparam logic [DW-1:0] ED   = 16'h00F0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    cfg_exit_mode = 2'b00;
    logic          done, pass, fail;
    logic          rd_req_valid;
    logic          rd_req_ready = 1'b0;
    logic          rd_rsp_valid = 1'b0;
    logic [DW-1:0] rd_rsp_data = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    always #2.5 clk = ~clk;

    tgl_poll_engine #(
        .DW(DW), .AW(AW), .MAX_POLLS(MAXP), .EXIT_ADDR(EA), .EXIT_DATA(ED)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_exit_mode(cfg_exit_mode),
        .done(done), .pass(pass), .fail(fail),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Scenario state shared by the driver and the per-clock monitor.
    logic [DW-1:0] scr[$];
    logic [DW-1:0] rq[$];
    int  lat = 0, rstall = 0, wstall = 0;
    bit  active = 0, seen_done = 0;
    int  cyc_n = 0, done_due = -1;
    bit  exp_pass = 0, exp_wr = 0;
    int  exp_reads = 0;
    int  reads_issued = 0, reads_done = 0, writes = 0;
    bit  hs_pending = 0, rsp_due = 0;
    int  rsp_wait = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: walk the scripted status words the way the rules say.
    function automatic void predict(input logic [1:0] mode, output bit p,
                                    output int nr, output bit w);
        int  i = 0;
        int  polls = 0;
        bit  fin = 0;
        p = 0;
        while (!fin && (i + 1) < scr.size()) begin
            bit a  = scr[i][6];
            bit b  = scr[i+1][6];
            bit fl = scr[i+1][3] | scr[i+1][5];
            i += 2;
            if (a == b) begin
                p = 1; fin = 1;
            end else if (fl) begin
                p = (scr[i][6] == scr[i+1][6]);
                i += 2; fin = 1;
            end else begin
                polls++;
                if (polls == MAXP) begin
                    p = 0; fin = 1;
                end
            end
        end
        nr = i;
        w  = !p || (mode != 2'b00);
    endfunction

    // Per-clock responder and monitor, working at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc_n++;
            if (hs_pending) begin
                rsp_due = 1; rsp_wait = lat; hs_pending = 0;
            end
            rd_rsp_valid = 1'b0;
            if (rsp_due) begin
                if (rsp_wait > 0) begin
                    rsp_wait--;
                end else begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = rq.pop_front();
                    rsp_due = 0;
                    reads_done++;
                    if (reads_done == exp_reads && !exp_wr) done_due = cyc_n + 1;
                end
            end
            if (active) begin
                chk(done === (cyc_n == done_due), "R10", "done timing",
                    int'(done), int'(cyc_n == done_due));
                if (wr_valid && !exp_wr)
                    chk(0, "R8", "unexpected exit write", 1, 0);
                if (done) begin
                    chk(pass === exp_pass, "R11", "pass at done", int'(pass), int'(exp_pass));
                    chk(fail === !exp_pass, "R11", "fail at done", int'(fail), int'(!exp_pass));
                    chk(reads_done == exp_reads, "R2", "reads taken", reads_done, exp_reads);
                    chk(writes == int'(exp_wr), "R9", "exit writes", writes, int'(exp_wr));
                    seen_done = 1;
                    active = 0;
                end
            end
            rd_req_ready = (rstall == 0) || (cyc_n % rstall != 0);
            if (rd_req_valid && rd_req_ready) begin
                reads_issued++;
                if (reads_issued > exp_reads) begin
                    chk(0, "R7", "read beyond verdict", reads_issued, exp_reads);
                    rq.push_back('0);
                end
                hs_pending = 1;
            end
            wr_ready = (wstall == 0) || (cyc_n % wstall != 0);
            if (wr_valid && wr_ready) begin
                writes++;
                chk(wr_addr == EA, "R10", "exit address", int'(wr_addr), int'(EA));
                chk(wr_data == ED, "R10", "exit data", int'(wr_data), int'(ED));
                if (exp_wr) done_due = cyc_n + 1;
            end
        end
    end

    task automatic run_case(input logic [1:0] mode, input int l, input int rs,
                            input int ws, input bit restart);
        int guard = 0;
        rq = scr;
        predict(mode, exp_pass, exp_reads, exp_wr);
        lat = l; rstall = rs; wstall = ws;
        reads_issued = 0; reads_done = 0; writes = 0;
        done_due = -1; seen_done = 0;
        @(negedge clk);
        cfg_exit_mode = mode;
        start = 1'b1;
        active = 1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            // R12: a second start and a mode change while busy are ignored.
            repeat (3) @(negedge clk);
            start = 1'b1;
            cfg_exit_mode = ~mode;
            @(negedge clk);
            start = 1'b0;
        end
        while (!seen_done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(seen_done, "R11", "done seen", int'(seen_done), 1);
        repeat (3) @(negedge clk);
        chk(pass === exp_pass, "R11", "pass held", int'(pass), int'(exp_pass));
        chk(fail === !exp_pass, "R11", "fail held", int'(fail), int'(!exp_pass));
        chk(rq.size() == 0, "R2", "script consumed", rq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done === 1'b0, "R1", "done in reset", int'(done), 0);
        chk(pass === 1'b0 && fail === 1'b0, "R1", "verdict in reset", int'({pass, fail}), 0);
        chk(rd_req_valid === 1'b0, "R1", "read req in reset", int'(rd_req_valid), 0);
        chk(wr_valid === 1'b0, "R1", "write in reset", int'(wr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_req_valid === 1'b0 && done === 1'b0, "R1", "idle after reset",
            int'({rd_req_valid, done}), 0);

        // R3, R8: settled at once, mode 00 -> pass, no write
        scr = {16'h0040, 16'h0040};
        run_case(2'b00, 0, 0, 0, 0);
        // R3: flags ignored when bit 6 is stable
        scr = {16'h0028, 16'h0028};
        run_case(2'b00, 2, 3, 0, 0);
        // R9: mode 01 pass still writes
        scr = {16'h0000, 16'h0000};
        run_case(2'b01, 1, 0, 2, 0);
        // R4, R12: toggle without flags, fresh pair, then settled; restart ignored
        scr = {16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0040};
        run_case(2'b00, 1, 0, 0, 1);
        // R4: flag on the first read only does not start a recheck
        scr = {16'h0020, 16'h0040, 16'h0040, 16'h0040};
        run_case(2'b00, 0, 2, 0, 0);
        // R5: bit 5 with toggle, recheck settled -> pass
        scr = {16'h0000, 16'h0060, 16'h0020, 16'h0020};
        run_case(2'b00, 0, 0, 0, 0);
        // R6, R8: bit 3 with toggle, recheck still toggles -> fail with write
        scr = {16'h0000, 16'h0048, 16'h0008, 16'h0048};
        run_case(2'b00, 1, 2, 3, 0);
        // R6, R9: same failure in mode 01
        scr = {16'h0040, 16'h0020, 16'h0060, 16'h0020};
        run_case(2'b01, 0, 0, 0, 0);
        // R9: mode 10 also always exits
        scr = {16'h0040, 16'h0040};
        run_case(2'b10, 0, 0, 2, 0);
        // R7: never settles -> fail after MAXP pairs
        scr = {16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0000,
               16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040};
        run_case(2'b00, 1, 3, 0, 0);
        // R5: recheck on the last allowed pair wins over the limit
        scr = {16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0000,
               16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0048,
               16'h0000, 16'h0000};
        run_case(2'b00, 0, 0, 0, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule